// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns a 32-bit IEEE-754 single-precision word into a signed two's-complement fixed-point word in one combinational pass. It sits between a float-based processor domain and fixed-point arithmetic hardware, so kernels written for floats can run on integer datapaths. The fixed width and the binary-point position are parameters. A parameter can instead hand the binary-point position to a runtime input, so one instance can serve several number formats.

Encodings that a fixed format cannot hold are classified before any arithmetic. Zeros, subnormals and infinities or NaNs each raise their own flag combination and give an all-zero data word. For ordinary values the 24-bit significand (hidden one plus stored fraction) is shifted left or right until it lines up with the fixed binary point. Bits that fall below the least significant fixed bit are dropped. A set sign bit then negates the result. A separate output reports how many more integer bits the value would need to fit.

Top module: `flt2fix_conv`

## Requirements
- R1: For a normal input with sign s, biased exponent e (bits 30:23, bias 127) and fraction m (bits 22:0), the magnitude equals {1,m} times 2 to the power (e - 150 + P), where P is the binary-point position. For example, 1.0 (0x3F800000) with P = 20 gives 0x00100000.
- R2: When e = 0 and m = 0, whatever the sign, zero_o is 1, normal_o and exc_o are 0, and fix_o and ovf_o are 0.
- R3: When e = 0 and m is nonzero (subnormal), zero_o, normal_o and exc_o are 0, and fix_o and ovf_o are 0.
- R4: When e = 255 (infinity or NaN), exc_o is 1, zero_o and normal_o are 0, and fix_o and ovf_o are 0.
- R5: normal_o is 1 exactly when 1 <= e <= 254. At most one of zero_o, normal_o and exc_o is ever 1.
- R6: When bit 31 is set on a normal input, fix_o is the two's complement of the magnitude.
- R7: Fraction bits below the fixed LSB are truncated toward zero on the magnitude, before any negation. So -2^-21 gives 0 and -(1.75 x 2^-20) gives 0xFFFFFFFF when P = 20.
- R8: ovf_o equals max(0, W - (FIX_W - 1)), where W is the bit width of the truncated magnitude. It is 0 for inputs that are not normal. For example, 2048.0 with P = 20 gives ovf_o = 1.
- R9: On overflow, fix_o holds the low FIX_W bits of the signed result that has wrapped.
- R10: With RADIX_FROM_PORT = 1, P is taken from radix_i.
- R11: With RADIX_FROM_PORT = 0, P is RADIX_POS and radix_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| float_i | input | FLOAT_W | Single-precision operand |
| radix_i | input | RADIX_W | Runtime binary-point position (used only when RADIX_FROM_PORT = 1) |
| fix_o | output | FIX_W | Two's-complement fixed-point result |
| zero_o | output | 1 | Operand is a signed zero |
| normal_o | output | 1 | Operand is a normal number |
| exc_o | output | 1 | Operand is an infinity or NaN |
| ovf_o | output | OVF_W | Extra integer bits needed to avoid overflow |

## Verification
The block has no state, so a wrong internal value shows at the ports in the same cycle as the operand that causes it. A fault in the classifier shows as a flag combination that breaks exclusivity, or as a nonzero data word on a special encoding. A wrong shift amount shows as a result off by a power of two, and in most cases also as a wrong overflow count. A negation fault shows as a sign mismatch on small negative values.

// File: rtl/flt2fix_pkg.sv
package flt2fix_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUB     = 2'd1,
    CLS_NORM    = 2'd2,
    CLS_SPECIAL = 2'd3
  } fcls_e;

  // Signed left-shift distance that places the significand LSB on the fixed grid.
  function automatic int align_shift(input int exp_biased, input int radix,
                                     input int bias, input int mant_w);
    return exp_biased - bias - mant_w + radix;
  endfunction

  // Extra integer bits needed beyond the FIX_W-1 magnitude bits of a signed word.
  function automatic int extra_bits(input int shift, input int sig_w, input int fix_w);
    int need;
    need = sig_w + shift;
    if (need > fix_w - 1) return need - (fix_w - 1);
    return 0;
  endfunction

  // Bit width of the largest overflow count a configuration can produce.
  function automatic int ovf_width(input int exp_w, input int mant_w,
                                   input int radix_w, input int fix_w);
    int bias, kmax, emax;
    bias = (1 << (exp_w - 1)) - 1;
    emax = (1 << exp_w) - 2;
    kmax = emax - bias - mant_w + (1 << radix_w) - 1;
    return $clog2(extra_bits(kmax, mant_w + 1, fix_w) + 2);
  endfunction

endpackage

// File: rtl/flt2fix_classify.sv
module flt2fix_classify
  import flt2fix_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  output fcls_e             cls_o
);
  logic exp_min, exp_max, frac_nz;

  assign exp_min = (exp_i == '0);
  assign exp_max = (exp_i == '1);
  assign frac_nz = |mant_i;

  always_comb begin
    if (exp_max)                 cls_o = CLS_SPECIAL;
    else if (exp_min && frac_nz) cls_o = CLS_SUB;
    else if (exp_min)            cls_o = CLS_ZERO;
    else                         cls_o = CLS_NORM;
  end
endmodule

// File: rtl/flt2fix_align.sv
module flt2fix_align
  import flt2fix_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MANT_W  = 23,
  parameter int FIX_W   = 32,
  parameter int RADIX_W = 6,
  parameter int OVF_W   = 8
) (
  input  logic [EXP_W-1:0]   exp_i,
  input  logic [MANT_W-1:0]  mant_i,
  input  logic [RADIX_W-1:0] radix_i,
  output logic [FIX_W-1:0]   mag_o,
  output logic [OVF_W-1:0]   ovf_o,
  output logic               shift_left_o
);
  localparam int SIG_W  = MANT_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int WIDE_W = FIX_W + SIG_W;

  logic [SIG_W-1:0]  sig;
  logic [WIDE_W-1:0] wide;
  logic [31:0]       ovf_full;
  int                shamt;

  assign sig = {1'b1, mant_i};

  always_comb begin
    shamt        = align_shift(int'(exp_i), int'(radix_i), BIAS, MANT_W);
    shift_left_o = (shamt >= 0);
    wide         = {{FIX_W{1'b0}}, sig};
    if (shift_left_o) wide = wide << shamt;
    else              wide = wide >> (-shamt);
    mag_o        = wide[FIX_W-1:0];
    ovf_full     = 32'(extra_bits(shamt, SIG_W, FIX_W));
    ovf_o        = ovf_full[OVF_W-1:0];
  end
endmodule

// File: rtl/flt2fix_signmask.sv
module flt2fix_signmask #(
  parameter int FIX_W = 32
) (
  input  logic             sign_i,
  input  logic             kill_i,
  input  logic [FIX_W-1:0] mag_i,
  output logic [FIX_W-1:0] fix_o
);
  logic [FIX_W-1:0] signed_val;

  assign signed_val = sign_i ? (~mag_i + 1'b1) : mag_i;
  assign fix_o      = signed_val & ~{FIX_W{kill_i}};
endmodule

// File: rtl/flt2fix_conv.sv
module flt2fix_conv
  import flt2fix_pkg::*;
#(
  parameter int FLOAT_W         = 32,
  parameter int EXP_W           = 8,
  parameter int MANT_W          = 23,
  parameter int FIX_W           = 32,
  parameter int RADIX_W         = 6,
  parameter int RADIX_POS       = 20,
  parameter bit RADIX_FROM_PORT = 1'b0,
  parameter int OVF_W           = ovf_width(EXP_W, MANT_W, RADIX_W, FIX_W)
) (
  input  logic [FLOAT_W-1:0] float_i,
  input  logic [RADIX_W-1:0] radix_i,
  output logic [FIX_W-1:0]   fix_o,
  output logic               zero_o,
  output logic               normal_o,
  output logic               exc_o,
  output logic [OVF_W-1:0]   ovf_o
);
  localparam int SIGN_BIT = FLOAT_W - 1;

  logic               sign_bit;
  logic [EXP_W-1:0]   exp_fld;
  logic [MANT_W-1:0]  mant_fld;
  logic [RADIX_W-1:0] radix_eff;
  fcls_e              cls;
  logic [FIX_W-1:0]   mag;
  logic [OVF_W-1:0]   ovf_raw;
  logic               shift_left;
  logic               kill_data;
  logic               is_sub;

  assign sign_bit = float_i[SIGN_BIT];
  assign exp_fld  = float_i[MANT_W +: EXP_W];
  assign mant_fld = float_i[MANT_W-1:0];

  generate
    if (RADIX_FROM_PORT) begin : g_radix_port
      assign radix_eff = radix_i;
    end else begin : g_radix_param
      logic unused_radix;
      assign unused_radix = ^radix_i;
      assign radix_eff    = RADIX_W'(RADIX_POS);
    end
  endgenerate

  flt2fix_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_classify (
    .exp_i  (exp_fld),
    .mant_i (mant_fld),
    .cls_o  (cls)
  );

  flt2fix_align #(
    .EXP_W(EXP_W), .MANT_W(MANT_W), .FIX_W(FIX_W),
    .RADIX_W(RADIX_W), .OVF_W(OVF_W)
  ) u_align (
    .exp_i        (exp_fld),
    .mant_i       (mant_fld),
    .radix_i      (radix_eff),
    .mag_o        (mag),
    .ovf_o        (ovf_raw),
    .shift_left_o (shift_left)
  );

  assign zero_o    = (cls == CLS_ZERO);
  assign normal_o  = (cls == CLS_NORM);
  assign exc_o     = (cls == CLS_SPECIAL);
  assign is_sub    = (cls == CLS_SUB);
  assign kill_data = zero_o | exc_o | is_sub;
  assign ovf_o     = normal_o ? ovf_raw : '0;

  logic unused_dir;
  assign unused_dir = shift_left;

  flt2fix_signmask #(.FIX_W(FIX_W)) u_signmask (
    .sign_i (sign_bit),
    .kill_i (kill_data),
    .mag_i  (mag),
    .fix_o  (fix_o)
  );
endmodule

// File: rtl/flt2fix_checker.sv
module flt2fix_checker #(
  parameter int FLOAT_W = 32,
  parameter int FIX_W   = 32,
  parameter int OVF_W   = 8
) (
  input logic [FLOAT_W-1:0] float_i,
  input logic [FIX_W-1:0]   fix_o,
  input logic               zero_o,
  input logic               normal_o,
  input logic               exc_o,
  input logic [OVF_W-1:0]   ovf_o
);
  always_comb begin
    assert_flags_onehot_R5: assert ($onehot0({zero_o, normal_o, exc_o}))
      else $error("flag exclusivity broken");
    if (zero_o)
      assert_zero_clears_R2: assert (fix_o == '0 && ovf_o == '0)
        else $error("zero input left data");
    if (exc_o)
      assert_exc_clears_R4: assert (fix_o == '0 && ovf_o == '0)
        else $error("exception input left data");
    if (!zero_o && !exc_o && !normal_o)
      assert_sub_flushed_R3: assert (fix_o == '0)
        else $error("subnormal not flushed");
    if (!normal_o)
      assert_ovf_only_normal_R8: assert (ovf_o == '0)
        else $error("overflow on non-normal");
    if (normal_o && ovf_o == '0 && fix_o != '0)
      assert_sign_kept_R6: assert (fix_o[FIX_W-1] == float_i[FLOAT_W-1])
        else $error("sign lost without overflow");
  end
endmodule

bind flt2fix_conv flt2fix_checker #(
  .FLOAT_W(FLOAT_W), .FIX_W(FIX_W), .OVF_W(OVF_W)
) u_chk (
  .float_i  (float_i),
  .fix_o    (fix_o),
  .zero_o   (zero_o),
  .normal_o (normal_o),
  .exc_o    (exc_o),
  .ovf_o    (ovf_o)
);

// File: tb/flt2fix_conv_bench.sv
`timescale 1ns/1ps
module flt2fix_conv_bench;
  localparam int FIXW = 32;
  localparam int PFIX = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] fin;
  logic [5:0]  rin;
  logic [31:0] fa, fb;
  logic        za, na, xa, zb, nb, xb;
  logic [7:0]  oa, ob;

  flt2fix_conv u_flt2fix_conv (
    .float_i(fin), .radix_i(rin), .fix_o(fa), .zero_o(za),
    .normal_o(na), .exc_o(xa), .ovf_o(oa)
  );

  flt2fix_conv #(.RADIX_FROM_PORT(1'b1)) u_flt2fix_conv_rt (
    .float_i(fin), .radix_i(rin), .fix_o(fb), .zero_o(zb),
    .normal_o(nb), .exc_o(xb), .ovf_o(ob)
  );

  typedef struct packed {
    logic [31:0] fx;
    logic        z;
    logic        n;
    logic        x;
    logic [7:0]  ov;
  } res_t;

  res_t  q_a[$];
  res_t  q_b[$];
  string q_tag[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // Reference: grow or shrink the significand one bit at a time.
  function automatic res_t model(input logic [31:0] f, input int p);
    res_t r;
    logic [255:0] v;
    int e, steps, w;
    r = '0;
    e = int'(f[30:23]);
    if (e == 255) r.x = 1'b1;
    else if (e == 0) r.z = (f[22:0] == 23'd0);
    else begin
      r.n   = 1'b1;
      v     = {232'd0, 1'b1, f[22:0]};
      steps = e - 150 + p;
      for (int i = 0; i < steps; i++) v = v * 2;
      for (int i = 0; i > steps; i--) v = v / 2;
      w = 0;
      for (int i = 0; i < 256; i++) if (v[i]) w = i + 1;
      if (w > FIXW - 1) r.ov = 8'(w - (FIXW - 1));
      if (f[31]) v = ~v + 1'b1;
      r.fx = v[31:0];
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] f, input logic [5:0] p, input string tag);
    @(posedge clk);
    fin = f;
    rin = p;
    q_a.push_back(model(f, PFIX));
    q_b.push_back(model(f, int'(p)));
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      res_t ea, eb;
      string t;
      ea = q_a.pop_front();
      eb = q_b.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if ({fa, za, na, xa, oa} !== ea) begin
        errors++;
        $display("FAIL %s param-radix got fix=%h z%b n%b x%b ov=%0d exp fix=%h z%b n%b x%b ov=%0d",
                 t, fa, za, na, xa, oa, ea.fx, ea.z, ea.n, ea.x, ea.ov);
      end
      checks++;
      if ({fb, zb, nb, xb, ob} !== eb) begin
        errors++;
        $display("FAIL %s port-radix got fix=%h z%b n%b x%b ov=%0d exp fix=%h z%b n%b x%b ov=%0d",
                 t, fb, zb, nb, xb, ob, eb.fx, eb.z, eb.n, eb.x, eb.ov);
      end
    end
  end

  initial begin
    fin = '0;
    rin = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state after reset: operand 0 must read as zero.
    drive(32'h0000_0000, 6'd20, "R2 reset idle zero");
    drive(32'h8000_0000, 6'd7,  "R2 negative zero");
    drive(32'h3F80_0000, 6'd20, "R1 one");
    drive(32'h4049_0FDB, 6'd20, "R1 pi");
    drive(32'h3F80_0000, 6'd0,  "R10 one at radix 0");
    drive(32'h4040_0000, 6'd30, "R10 three at radix 30");
    drive(32'h3F80_0000, 6'd63, "R10 R9 one at radix 63");
    drive(32'hBF80_0000, 6'd20, "R6 minus one");
    drive(32'hC2F6_E979, 6'd12, "R6 negative fraction");
    drive(32'h3500_0000, 6'd20, "R7 below lsb");
    drive(32'hB500_0000, 6'd20, "R7 negative below lsb");
    drive(32'h35E0_0000, 6'd20, "R7 positive truncation");
    drive(32'hB5E0_0000, 6'd20, "R7 negative truncation");
    drive(32'h0000_0001, 6'd20, "R3 smallest subnormal");
    drive(32'h807F_FFFF, 6'd60, "R3 largest negative subnormal");
    drive(32'h7F80_0000, 6'd20, "R4 plus infinity");
    drive(32'hFF80_0000, 6'd20, "R4 minus infinity");
    drive(32'h7FC0_0000, 6'd20, "R4 NaN");
    drive(32'h0080_0000, 6'd63, "R5 smallest normal");
    drive(32'h7F7F_FFFF, 6'd20, "R5 R8 largest normal");
    drive(32'h4480_0000, 6'd20, "R8 1024 fits");
    drive(32'h4500_0000, 6'd20, "R8 R9 2048 overflows by one");
    drive(32'hC500_0000, 6'd20, "R8 R9 minus 2048");
    drive(32'h5380_0000, 6'd20, "R8 R9 two to the 40");
    drive(32'h4120_0000, 6'd0,  "R11 radix_i 0 ignored");
    drive(32'h4120_0000, 6'd45, "R11 radix_i 45 ignored");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] f;
      f = 32'h3F80_0000 ^ (32'h9E37_79B9 * (i + 1));
      drive(f, 6'(i * 7), "R1 R6 R8 R10 sweep");
    end
    @(posedge clk);
    wait (q_tag.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule